// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches software through a slow time base. A 1024 Hz tick arrives as a single-cycle enable pulse on the system clock. The watchdog counts those ticks and raises a one-cycle reset request if software fails to clear it in time. In normal mode there is only a time-out span, and a clear inside it restarts the count. In window mode a closed span comes first. A clear during the closed span is a fault and raises the reset request at once. An open span follows, and a clear during it restarts the sequence.

Both span lengths come from one configuration byte that holds two 4-bit codes. Code N in the range 0x0 to 0xB gives 8·2^N ticks. The byte is loaded from a default input at reset. Software can change it only while the watchdog is disabled. A write that carries a reserved code is refused and sets a sticky error flag. The mode input is captured on every cycle while the watchdog is disabled and is frozen while it runs.

Top module: `window_watchdog`

## Requirements
- R1: During reset the configuration byte takes the value on `cfg_default_i`, and `cfg_err_o` and `rst_req_o` go low.
- R2: While `wdg_en_i` is low, a write with `cfg_wr_i` stores `cfg_wdata_i`. The stored byte reads back on `cfg_rdata_o`. Bits 7:4 hold the closed-span code and bits 3:0 hold the time-out or open-span code.
- R3: While `wdg_en_i` is high, configuration writes are ignored and `cfg_rdata_o` reads as 0x00.
- R4: A write in which either 4-bit field is 0xC..0xF is refused, and the stored byte keeps its old value. Such a write sets `cfg_err_o`, which then stays high until reset.
- R5: A code N gives a span of 8·2^N ticks, from 8 ticks for N=0 to 16384 ticks for N=0xB. Only cycles with `tick_i` high advance the count.
- R6: In normal mode (`win_mode_i` low while disabled), `rst_req_o` goes high for exactly one cycle. That cycle follows the clock edge that takes the tick completing the time-out span, provided no clear came after the last restart.
- R7: A clear in normal mode, or during the open span in window mode, restarts the sequence from its start and raises no reset request.
- R8: In window mode, a clear during the closed span raises `rst_req_o` in the next cycle and restarts the closed span. A clear has priority over a tick that arrives in the same cycle.
- R9: In window mode the open span begins once the closed span's ticks have elapsed. Without a clear, the reset request follows the tick numbered (closed + open).
- R10: While `wdg_en_i` is low the count is held at its start and no reset request appears. Enabling again starts a fresh sequence. Changes to `win_mode_i` while enabled have no effect.
- R11: After a time-out the sequence restarts: in window mode it returns to the closed span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 1024 Hz time base, one-cycle enable pulse |
| clear_i | input | 1 | Clear request from software |
| wdg_en_i | input | 1 | Watchdog enable; high also locks the configuration |
| win_mode_i | input | 1 | Window mode select, captured while disabled |
| cfg_default_i | input | 8 | Configuration value loaded at reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data (0x00 while enabled) |
| cfg_err_o | output | 1 | Sticky flag for a refused reserved-code write |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions take for granted that `cfg_default_i` holds valid codes in both fields, so the stored byte is always legal. They also assume reset is held for at least two clock edges, so sticky and stability checks have a defined prior value. The stimulus drives only valid defaults and holds reset for several cycles. It changes `win_mode_i` before raising the enable. Tick pulses last exactly one cycle, with random idle gaps between them. Random period codes stay small so that each span runs to completion within the cycle budget. One directed case covers the largest code.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CODE_W     = 4;
    localparam int NUM_FIELDS = 2;
    localparam int CFG_W      = CODE_W * NUM_FIELDS;
    localparam int MAX_CODE   = 11;
    localparam int BASE_LOG2  = 3;
    localparam int CNT_W      = BASE_LOG2 + MAX_CODE;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // field order matters: closed-span code in the upper nibble
    typedef struct packed {
        code_t win;
        code_t per;
    } cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CLOSED = 2'd1,
        PH_OPEN   = 2'd2
    } phase_e;

    function automatic logic code_ok(code_t c);
        return ({28'd0, c} <= 32'(MAX_CODE));
    endfunction

    // last count value of a span: 8 * 2^N - 1 ticks, code clamped to the legal range
    function automatic cnt_t span_last(code_t c);
        logic [31:0] n;
        logic [31:0] full;
        n    = code_ok(c) ? {28'd0, c} : 32'(MAX_CODE);
        full = (32'd1 << (32'(BASE_LOG2) + n)) - 32'd1;
        return full[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/wdog_span.sv
module wdog_span
    import wdog_pkg::*;
(
    input  code_t code_i,
    output cnt_t  last_o
);

    always_comb begin
        last_o = span_last(code_i);
    end

endmodule

// File: rtl/wdog_cfg_bank.sv
module wdog_cfg_bank
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_default_i,
    input  logic wr_i,
    input  cfg_t wdata_i,
    input  logic armed_i,
    input  logic mode_i,
    output cfg_t cfg_o,
    output logic mode_o,
    output cfg_t rdata_o,
    output logic err_o
);

    cfg_t                  cfg_q;
    logic                  mode_q;
    logic                  err_q;
    logic [NUM_FIELDS-1:0] field_ok;
    logic [CFG_W-1:0]      wbits;

    assign wbits = wdata_i;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign field_ok[f] = code_ok(wbits[f*CODE_W +: CODE_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= cfg_default_i;
            mode_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (!armed_i) begin
            mode_q <= mode_i;
            if (wr_i) begin
                if (&field_ok) begin
                    cfg_q <= wdata_i;
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    assign cfg_o   = cfg_q;
    assign mode_o  = mode_q;
    assign err_o   = err_q;
    assign rdata_o = armed_i ? cfg_t'('0) : cfg_q;

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
    import wdog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en_i,
    input  logic   tick_i,
    input  logic   clear_i,
    input  logic   win_mode_i,
    input  cnt_t   win_last_i,
    input  cnt_t   per_last_i,
    output phase_e phase_o,
    output cnt_t   cnt_o,
    output logic   req_o
);

    phase_e phase_q;
    phase_e start_ph;
    phase_e cur_ph;
    cnt_t   cnt_q;
    logic   req_q;

    always_comb begin
        start_ph = win_mode_i ? PH_CLOSED : PH_OPEN;
        cur_ph   = (phase_q == PH_IDLE) ? start_ph : phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            req_q   <= 1'b0;
        end else begin
            req_q <= 1'b0;
            unique case (cur_ph)
                PH_CLOSED: begin
                    if (clear_i) begin
                        req_q   <= 1'b1;
                        phase_q <= PH_CLOSED;
                        cnt_q   <= '0;
                    end else if (tick_i) begin
                        if (cnt_q == win_last_i) begin
                            phase_q <= PH_OPEN;
                            cnt_q   <= '0;
                        end else begin
                            phase_q <= PH_CLOSED;
                            cnt_q   <= cnt_q + cnt_t'(1);
                        end
                    end else begin
                        phase_q <= PH_CLOSED;
                    end
                end
                default: begin
                    if (clear_i) begin
                        phase_q <= start_ph;
                        cnt_q   <= '0;
                    end else if (tick_i) begin
                        if (cnt_q == per_last_i) begin
                            req_q   <= 1'b1;
                            phase_q <= start_ph;
                            cnt_q   <= '0;
                        end else begin
                            phase_q <= PH_OPEN;
                            cnt_q   <= cnt_q + cnt_t'(1);
                        end
                    end else begin
                        phase_q <= PH_OPEN;
                    end
                end
            endcase
        end
    end

    assign phase_o = phase_q;
    assign cnt_o   = cnt_q;
    assign req_o   = req_q;

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       clear_i,
    input  logic       wdg_en_i,
    input  logic       win_mode_i,
    input  logic [7:0] cfg_default_i,
    input  logic       cfg_wr_i,
    input  logic [7:0] cfg_wdata_i,
    output logic [7:0] cfg_rdata_o,
    output logic       cfg_err_o,
    output logic       rst_req_o
);

    cfg_t             cfg_w;
    cfg_t             rdata_w;
    logic             mode_w;
    logic [CFG_W-1:0] cfg_bits;
    cnt_t             last_w [NUM_FIELDS];
    phase_e           phase_w;
    cnt_t             cnt_w;

    wdog_cfg_bank u_cfg (
        .clk           (clk),
        .rst           (rst),
        .cfg_default_i (cfg_t'(cfg_default_i)),
        .wr_i          (cfg_wr_i),
        .wdata_i       (cfg_t'(cfg_wdata_i)),
        .armed_i       (wdg_en_i),
        .mode_i        (win_mode_i),
        .cfg_o         (cfg_w),
        .mode_o        (mode_w),
        .rdata_o       (rdata_w),
        .err_o         (cfg_err_o)
    );

    assign cfg_bits    = cfg_w;
    assign cfg_rdata_o = rdata_w;

    // field 0: time-out / open span, field 1: closed span
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_span
        wdog_span u_span (
            .code_i (cfg_bits[f*CODE_W +: CODE_W]),
            .last_o (last_w[f])
        );
    end

    wdog_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .en_i       (wdg_en_i),
        .tick_i     (tick_i),
        .clear_i    (clear_i),
        .win_mode_i (mode_w),
        .win_last_i (last_w[1]),
        .per_last_i (last_w[0]),
        .phase_o    (phase_w),
        .cnt_o      (cnt_w),
        .req_o      (rst_req_o)
    );

endmodule

// File: rtl/window_watchdog_chk.sv
module window_watchdog_chk
    import wdog_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   en_i,
    input logic   tick_i,
    input logic   clear_i,
    input phase_e phase_i,
    input cnt_t   cnt_i,
    input cnt_t   win_last_i,
    input cnt_t   per_last_i,
    input cfg_t   cfg_i,
    input logic   err_i,
    input logic   req_i
);

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_i <= ((phase_i == PH_CLOSED) ? win_last_i : per_last_i));

    assert_codes_legal_R4: assert property (@(posedge clk) disable iff (rst)
        code_ok(cfg_i.win) && code_ok(cfg_i.per));

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        $past(err_i) |-> err_i);

    assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (rst)
        (en_i && $past(en_i)) |-> $stable(cfg_i));

    assert_req_cause_R6: assert property (@(posedge clk) disable iff (rst)
        req_i |-> ($past(clear_i) || $past(tick_i)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(en_i) |-> !req_i);

    assert_closed_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (en_i && phase_i == PH_CLOSED && clear_i) |=> req_i);

    assert_open_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (en_i && phase_i == PH_OPEN && clear_i) |=> !req_i);

endmodule

bind window_watchdog window_watchdog_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_i       (wdg_en_i),
    .tick_i     (tick_i),
    .clear_i    (clear_i),
    .phase_i    (phase_w),
    .cnt_i      (cnt_w),
    .win_last_i (last_w[1]),
    .per_last_i (last_w[0]),
    .cfg_i      (cfg_w),
    .err_i      (cfg_err_o),
    .req_i      (rst_req_o)
);

// File: tb/window_watchdog_tb.sv
`timescale 1ns/1ps
module window_watchdog_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       clr = 1'b0;
    logic       en = 1'b0;
    logic       mode = 1'b0;
    logic [7:0] dflt = 8'h10;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       err;
    logic       req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    window_watchdog u_dut (
        .clk           (clk),
        .rst           (rst),
        .tick_i        (tick),
        .clear_i       (clr),
        .wdg_en_i      (en),
        .win_mode_i    (mode),
        .cfg_default_i (dflt),
        .cfg_wr_i      (wr),
        .cfg_wdata_i   (wdata),
        .cfg_rdata_o   (rdata),
        .cfg_err_o     (err),
        .rst_req_o     (req)
    );

    function automatic int span(input int code);
        return 8 << code;
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic c);
        @(negedge clk);
        tick = t;
        clr  = c;
        @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic [7:0] d);
        @(negedge clk);
        wr    = 1'b1;
        wdata = d;
        tick  = 1'b0;
        clr   = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic arm(input logic m);
        @(negedge clk);
        en   = 1'b0;
        mode = m;
        tick = 1'b0;
        clr  = 1'b0;
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic disarm();
        @(negedge clk);
        en   = 1'b0;
        tick = 1'b0;
        clr  = 1'b0;
        @(posedge clk);
        #1;
    endtask

    // drive n ticks with random idle gaps; request expected only after tick number fire_at
    task automatic run_ticks(input int n, input int fire_at, input int max_gap, input string rq);
        for (int j = 1; j <= n; j++) begin
            int gap;
            gap = (max_gap > 0) ? int'($urandom_range(0, max_gap)) : 0;
            for (int g = 0; g < gap; g++) begin
                cyc(1'b0, 1'b0);
                check(req == 1'b0, rq, req, 0);
            end
            cyc(1'b1, 1'b0);
            check(req == (j == fire_at), rq, req, (j == fire_at));
        end
    endtask

    task automatic do_clear(input logic exp, input string rq);
        cyc(1'b0, 1'b1);
        check(req == exp, rq, req, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R1: reset state
        check(rdata == 8'h10, "R1", rdata, 8'h10);
        check(err == 1'b0, "R1", err, 0);
        check(req == 1'b0, "R1", req, 0);

        // R2: write while disabled
        write_cfg(8'h21);
        check(rdata == 8'h21, "R2", rdata, 8'h21);

        // R4: reserved codes in either field refused, sticky error
        write_cfg(8'hC0);
        check(rdata == 8'h21, "R4", rdata, 8'h21);
        check(err == 1'b1, "R4", err, 1);
        write_cfg(8'h0D);
        check(rdata == 8'h21, "R4", rdata, 8'h21);
        write_cfg(8'h00);
        check(rdata == 8'h00, "R4", rdata, 8'h00);
        check(err == 1'b1, "R4", err, 1);

        // R6 / R11: normal time-out of 8 ticks, one-cycle pulse, restart
        arm(1'b0);
        run_ticks(8, 8, 0, "R6");
        cyc(1'b0, 1'b0);
        check(req == 1'b0, "R6", req, 0);
        run_ticks(8, 8, 2, "R11");

        // R7: clear in normal mode restarts the count
        run_ticks(5, 0, 1, "R7");
        do_clear(1'b0, "R7");
        run_ticks(8, 8, 1, "R7");

        // R3: locked while enabled
        write_cfg(8'h33);
        check(rdata == 8'h00, "R3", rdata, 8'h00);
        disarm();
        check(rdata == 8'h00, "R3", rdata, 8'h00);

        // R8 / R9 / R11: window, closed 16 ticks, open 8 ticks
        write_cfg(8'h10);
        arm(1'b1);
        run_ticks(3, 0, 1, "R9");
        do_clear(1'b1, "R8");
        run_ticks(16, 0, 1, "R9");
        do_clear(1'b0, "R7");
        run_ticks(24, 24, 1, "R9");
        run_ticks(2, 0, 0, "R11");
        do_clear(1'b1, "R11");
        cyc(1'b1, 1'b1);
        check(req == 1'b1, "R8", req, 1);

        // R10: disable holds, mode change while enabled ignored
        run_ticks(10, 0, 0, "R10");
        disarm();
        for (int k = 0; k < 20; k++) begin
            cyc(1'b1, 1'b0);
            check(req == 1'b0, "R10", req, 0);
        end
        arm(1'b1);
        @(negedge clk);
        mode = 1'b0;
        run_ticks(3, 0, 0, "R10");
        do_clear(1'b1, "R10");
        disarm();

        // R5: largest code, 16384 ticks
        write_cfg(8'h0B);
        arm(1'b0);
        run_ticks(16384, 16384, 0, "R5");
        disarm();

        // R5 / R6 / R7 / R8 / R9: random codes, modes, gaps and clear points
        for (int it = 0; it < 40; it++) begin
            int w;
            int p;
            int m;
            int closed;
            int total;
            int k;
            w = int'($urandom_range(0, 3));
            p = int'($urandom_range(0, 3));
            m = int'($urandom_range(0, 1));
            write_cfg(8'((w << 4) | p));
            check(rdata == 8'((w << 4) | p), "R2", rdata, (w << 4) | p);
            arm(m[0]);
            closed = m ? span(w) : 0;
            total  = closed + span(p);
            k = int'($urandom_range(1, total));
            run_ticks(k, total, 2, m ? "R9" : "R6");
            if (k < total) begin
                do_clear(k < closed, (k < closed) ? "R8" : "R7");
            end
            disarm();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule